// File: doc/BRIEF.md
# Multiport RAM Request Arbiter

This block lets several independent masters share one word-wide RAM port. Examples are a processor data port, a display fetch unit and a DMA engine. Each master drives its own request: a strobe, a read/write flag, a byte-enable mask, a word address and write data. It gets back a one-cycle completion pulse and a shared read-data bus. The arbiter grants one requesting master at a time in rotating order. It copies that master's request into a holding register and presents it on the RAM side as a strobe/ready request of the same kind. When the RAM answers, the arbiter returns a completion pulse to the granted master only.

Both edges of the block use the same handshake, and neither side can apply back-pressure. A master raises its strobe and holds it with all fields steady until it sees its ready pulse. Ready lasts exactly one cycle and read data is valid only in that cycle, so the master must take the data then. A strobe that is still high in the ready cycle is ignored. If the master keeps it high, a new transfer is requested from the next cycle. The RAM side follows the same rules, with the arbiter acting as the master. How long a request waits depends on traffic from the other ports.

Top module: `ram_port_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `mem_strobe` is low and no bit of `mst_ready` is high.
- R2: Each accepted transfer produces exactly one `mst_ready` pulse, one cycle long, and at most one bit of `mst_ready` is high in any cycle.
- R3: The ready pulse goes only to the granted port, in the cycle after the clock edge where `mem_strobe` and `mem_ready` are both high. In that cycle `mst_rdata` equals the `mem_rdata` value present at that edge.
- R4: While `mem_strobe` is high, `mem_addr`, `mem_write`, `mem_bsel` and `mem_wdata` equal the values the granted port presented when it was granted, and they stay stable until `mem_ready`.
- R5: When idle, an eligible strobe seen at a clock edge raises `mem_strobe` after that edge. `mem_strobe` stays high up to and including the `mem_ready` cycle, and it is low in the next cycle.
- R6: The grant rotates. The search starts at the port after the most recently granted one, in ascending index order with wrap-around. After reset, port 0 has first priority.
- R7: A port's strobe is ignored in the cycle its ready is high. A port that holds its strobe high continuously gets exactly one transfer per ready pulse, and no duplicate transfer.
- R8: Each port's `mst_bsel` nibble (port p at bits 4p+3..4p) is forwarded unchanged, with bit 3 enabling data bits 31:24 and bit 0 enabling bits 7:0. Read data returns the full 32-bit word with no masking. Port p's address occupies `mst_addr` bits 30p+29..30p, and its data occupies `mst_wdata` bits 32p+31..32p.
- R9: While a RAM transfer is outstanding, no other port is granted. Other requests wait for a variable number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_strobe | input | NPORT | Per-port request strobe |
| mst_write | input | NPORT | Per-port write flag (1 = write, 0 = read) |
| mst_bsel | input | NPORT*4 | Per-port byte enables |
| mst_addr | input | NPORT*ADDR_W | Per-port word address |
| mst_wdata | input | NPORT*DATA_W | Per-port write data |
| mst_rdata | output | DATA_W | Read data, valid only with a ready pulse |
| mst_ready | output | NPORT | Per-port one-cycle completion pulse |
| mem_strobe | output | 1 | RAM request strobe |
| mem_write | output | 1 | RAM write flag |
| mem_bsel | output | DATA_W/8 | RAM byte enables |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data |
| mem_ready | input | 1 | RAM one-cycle completion pulse |

## Verification
Suppose the stored owner index is corrupted. The next completion pulse then lands on the wrong `mst_ready` bit one cycle after `mem_ready`, and the master that is still waiting never finishes. A wrong rotation pointer shows up only at the next cycle in which two or more ports contend, as a different completion order. A holding register that is loaded at the wrong time shows up at once as `mem_addr` or `mem_wdata` moving while `mem_strobe` is high. The bench compares every port on every clock against a behavioural model, so any of these faults is caught within the cycle in which it first becomes visible.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int DEF_NPORT  = 3;
  localparam int DEF_ADDR_W = 30;
  localparam int DEF_DATA_W = 32;

  typedef enum logic {ARB_IDLE = 1'b0, ARB_BUSY = 1'b1} arb_state_e;
endpackage

// File: rtl/sra_rr_pick.sv
module sra_rr_pick #(
  parameter int NPORT = 3,
  parameter int IDX_W = 2
) (
  input  logic [NPORT-1:0] req,
  input  logic [IDX_W-1:0] last,
  output logic             any,
  output logic [IDX_W-1:0] win
);
  logic [IDX_W:0] cand;

  // scan ports last+1, last+2, ... with wrap, first requester wins
  always_comb begin
    any  = 1'b0;
    win  = '0;
    cand = '0;
    for (int off = 1; off <= NPORT; off++) begin
      cand = {1'b0, last} + (IDX_W+1)'(off);
      if (cand >= (IDX_W+1)'(NPORT)) cand = cand - (IDX_W+1)'(NPORT);
      if (!any && req[cand[IDX_W-1:0]]) begin
        any = 1'b1;
        win = cand[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sra_req_mux.sv
module sra_req_mux #(
  parameter int NPORT = 3,
  parameter int REC_W = 67,
  parameter int IDX_W = 2
) (
  input  logic [NPORT*REC_W-1:0] rec_flat,
  input  logic [IDX_W-1:0]       sel,
  output logic [REC_W-1:0]       rec
);
  always_comb begin
    rec = '0;
    for (int p = 0; p < NPORT; p++)
      if (sel == IDX_W'(p)) rec = rec_flat[p*REC_W +: REC_W];
  end
endmodule

// File: rtl/sra_ack_decode.sv
module sra_ack_decode #(
  parameter int NPORT = 3,
  parameter int IDX_W = 2
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [NPORT-1:0] onehot
);
  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    assign onehot[p] = en && (idx == IDX_W'(p));
  end
endmodule

// File: rtl/ram_port_arbiter.sv
module ram_port_arbiter
  import sra_pkg::*;
#(
  parameter int NPORT  = DEF_NPORT,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        mst_strobe,
  input  logic [NPORT-1:0]        mst_write,
  input  logic [NPORT*(DATA_W/8)-1:0] mst_bsel,
  input  logic [NPORT*ADDR_W-1:0] mst_addr,
  input  logic [NPORT*DATA_W-1:0] mst_wdata,
  output logic [DATA_W-1:0]       mst_rdata,
  output logic [NPORT-1:0]        mst_ready,
  output logic                    mem_strobe,
  output logic                    mem_write,
  output logic [DATA_W/8-1:0]     mem_bsel,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    mem_ready
);
  localparam int SEL_W = DATA_W / 8;
  localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int REC_W = 1 + SEL_W + ADDR_W + DATA_W;

  arb_state_e              state_q;
  logic [IDX_W-1:0]        owner_q, last_q, pick_idx;
  logic [NPORT-1:0]        ack_q, ack_d, elig;
  logic [DATA_W-1:0]       rdata_q;
  logic [REC_W-1:0]        req_q, pick_rec;
  logic [NPORT*REC_W-1:0]  rec_flat;
  logic                    pick_any, done;

  // pack each port's request fields into one record
  for (genvar p = 0; p < NPORT; p++) begin : g_pack
    assign rec_flat[p*REC_W +: REC_W] = {mst_write[p],
                                         mst_bsel[p*SEL_W +: SEL_W],
                                         mst_addr[p*ADDR_W +: ADDR_W],
                                         mst_wdata[p*DATA_W +: DATA_W]};
  end

  // a strobe seen during its own ready cycle does not count
  assign elig = mst_strobe & ~ack_q;
  assign done = (state_q == ARB_BUSY) && mem_ready;

  sra_rr_pick #(.NPORT(NPORT), .IDX_W(IDX_W)) u_pick (
    .req(elig), .last(last_q), .any(pick_any), .win(pick_idx)
  );

  sra_req_mux #(.NPORT(NPORT), .REC_W(REC_W), .IDX_W(IDX_W)) u_mux (
    .rec_flat(rec_flat), .sel(pick_idx), .rec(pick_rec)
  );

  sra_ack_decode #(.NPORT(NPORT), .IDX_W(IDX_W)) u_ack (
    .en(done), .idx(owner_q), .onehot(ack_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      owner_q <= '0;
      last_q  <= IDX_W'(NPORT-1);
      ack_q   <= '0;
      rdata_q <= '0;
      req_q   <= '0;
    end else begin
      ack_q <= ack_d;
      unique case (state_q)
        ARB_IDLE: if (pick_any) begin
          state_q <= ARB_BUSY;
          owner_q <= pick_idx;
          last_q  <= pick_idx;
          req_q   <= pick_rec;
        end
        ARB_BUSY: if (mem_ready) begin
          state_q <= ARB_IDLE;
          rdata_q <= mem_rdata;
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign mem_strobe = (state_q == ARB_BUSY);
  assign {mem_write, mem_bsel, mem_addr, mem_wdata} = req_q;
  assign mst_rdata  = rdata_q;
  assign mst_ready  = ack_q;

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_ready)) else $error("ack not onehot"); // R2
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && mem_ready) |=> $onehot(mst_ready)) else $error("missing ack"); // R3
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_strobe && mem_ready) |=> (mst_ready == '0)) else $error("stray ack"); // R3
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && !mem_ready) |=> mem_strobe) else $error("strobe dropped"); // R5
  AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && mem_ready) |=> !mem_strobe) else $error("strobe held"); // R5
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata) &&
                                    $stable(mem_bsel) && $stable(mem_write)))
    else $error("fields moved"); // R4
  AST_PICK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> elig[pick_idx]) else $error("picked idle port"); // R6
endmodule

// File: tb/ram_port_arbiter_test.sv
`timescale 1ns/1ps
module ram_port_arbiter_test;
  localparam int NP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0]    ms_strobe = '0, ms_write = '0;
  logic [NP*4-1:0]  ms_bsel = '0;
  logic [NP*30-1:0] ms_addr = '0;
  logic [NP*32-1:0] ms_wdata = '0;
  logic [31:0] m_rdata;
  logic [NP-1:0] m_ready;
  logic mr_strobe, mr_write, mr_ready = 1'b0;
  logic [3:0] mr_bsel;
  logic [29:0] mr_addr;
  logic [31:0] mr_wdata, mr_rdata = '0;

  ram_port_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .mst_strobe(ms_strobe), .mst_write(ms_write), .mst_bsel(ms_bsel),
    .mst_addr(ms_addr), .mst_wdata(ms_wdata), .mst_rdata(m_rdata), .mst_ready(m_ready),
    .mem_strobe(mr_strobe), .mem_write(mr_write), .mem_bsel(mr_bsel),
    .mem_addr(mr_addr), .mem_wdata(mr_wdata), .mem_rdata(mr_rdata), .mem_ready(mr_ready)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int credits[NP];
  bit eager = 1, fix_en = 0;
  logic        fx_wr[NP];
  logic [3:0]  fx_bs[NP];
  logic [29:0] fx_ad[NP];
  logic [31:0] fx_wd[NP];
  logic [31:0] last_rd[NP];
  int log_q[$];
  logic [31:0] mem[16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: busy flag, owner, rotation pointer, pending pulses
  bit e_busy = 0;
  int e_own = 0, e_last = NP-1;
  logic [NP-1:0] e_rdy = '0;
  logic [31:0] e_rdata = '0, e_wd = '0;
  logic [29:0] e_ad = '0;
  logic [3:0]  e_bs = '0;
  logic        e_wr = 0;

  always @(posedge clk) begin
    logic [NP-1:0] n_rdy;
    bit found;
    int c;
    if (!rst_n) begin
      e_busy = 0; e_last = NP-1; e_rdy = '0; e_rdata = '0;
    end else begin
      n_rdy = '0;
      found = 0;
      if (e_busy) begin
        if (mr_ready) begin
          e_busy = 0; n_rdy[e_own] = 1'b1; e_rdata = mr_rdata;
        end
      end else begin
        for (int k = 1; k <= NP; k++) begin
          c = (e_last + k) % NP;
          if (!found && ms_strobe[c] && !e_rdy[c]) begin
            found = 1; e_own = c;
            e_wr = ms_write[c]; e_bs = ms_bsel[c*4 +: 4];
            e_ad = ms_addr[c*30 +: 30]; e_wd = ms_wdata[c*32 +: 32];
          end
        end
        if (found) begin e_busy = 1; e_last = e_own; end
      end
      e_rdy = n_rdy;
    end
  end

  always @(negedge clk) begin
    chk(mr_strobe == e_busy, "R5/R9 mem_strobe", 32'(mr_strobe), 32'(e_busy));
    chk(m_ready == e_rdy, "R3 ready pulse port", 32'(m_ready), 32'(e_rdy));
    chk($countones(m_ready) <= 1, "R2 single ready", 32'(m_ready), 32'h1);
    if (e_busy) begin
      chk(mr_addr == e_ad, "R4 mem_addr", 32'(mr_addr), 32'(e_ad));
      chk(mr_wdata == e_wd, "R4 mem_wdata", mr_wdata, e_wd);
      chk(mr_bsel == e_bs, "R8 mem_bsel", 32'(mr_bsel), 32'(e_bs));
      chk(mr_write == e_wr, "R4 mem_write", 32'(mr_write), 32'(e_wr));
    end
    if (|e_rdy) chk(m_rdata == e_rdata, "R3 read data", m_rdata, e_rdata);
  end

  // RAM model: 1..4 cycle latency, byte-enabled writes, garbage data off-cycle
  initial begin
    int wait_n = -1;
    for (int i = 0; i < 16; i++) mem[i] = 32'(i) * 32'h01010101;
    forever begin
      @(negedge clk);
      mr_rdata = $urandom;
      if (mr_ready) mr_ready = 1'b0;
      else if (mr_strobe) begin
        if (wait_n < 0) wait_n = $urandom_range(3);
        if (wait_n == 0) begin
          wait_n = -1;
          mr_ready = 1'b1;
          mr_rdata = mem[mr_addr[3:0]];
          if (mr_write)
            for (int b = 0; b < 4; b++)
              if (mr_bsel[b]) mem[mr_addr[3:0]][b*8 +: 8] = mr_wdata[b*8 +: 8];
        end else wait_n--;
      end
    end
  end

  task automatic set_fields(input int p);
    if (fix_en) begin
      ms_write[p] = fx_wr[p]; ms_bsel[p*4 +: 4] = fx_bs[p];
      ms_addr[p*30 +: 30] = fx_ad[p]; ms_wdata[p*32 +: 32] = fx_wd[p];
    end else begin
      ms_write[p] = 1'($urandom); ms_bsel[p*4 +: 4] = 4'($urandom);
      ms_addr[p*30 +: 30] = 30'($urandom); ms_wdata[p*32 +: 32] = $urandom;
    end
  endtask

  // master drivers: hold strobe until ready, keep it high if more work is queued
  initial begin
    for (int p = 0; p < NP; p++) credits[p] = 0;
    forever begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        if (ms_strobe[p] && m_ready[p]) begin
          log_q.push_back(p);
          last_rd[p] = m_rdata;
          credits[p]--;
          if (credits[p] > 0) set_fields(p);
          else ms_strobe[p] = 1'b0;
        end else if (!ms_strobe[p] && credits[p] > 0 && (eager || $urandom_range(2) == 0)) begin
          set_fields(p);
          ms_strobe[p] = 1'b1;
        end
      end
    end
  end

  task automatic wait_idle();
    do begin @(negedge clk); #1; end
    while (credits[0] != 0 || credits[1] != 0 || credits[2] != 0 || ms_strobe != '0);
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic one_xfer(input int p, input logic wr, input logic [3:0] bs,
                          input logic [29:0] ad, input logic [31:0] wd);
    fx_wr[p] = wr; fx_bs[p] = bs; fx_ad[p] = ad; fx_wd[p] = wd;
    credits[p] = 1;
    wait_idle();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(mr_strobe == 1'b0, "R1 reset mem_strobe", 32'(mr_strobe), 0);
    chk(m_ready == '0, "R1 reset ready", 32'(m_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(mr_strobe == 1'b0 && m_ready == '0, "R1 idle after reset", 32'({mr_strobe, m_ready}), 0);

    // R6: all three at once after reset -> 0,1,2
    log_q.delete();
    credits[0] = 1; credits[1] = 1; credits[2] = 1;
    wait_idle();
    chk(log_q.size() == 3, "R2 one pulse per transfer", 32'(log_q.size()), 3);
    if (log_q.size() == 3) begin
      chk(log_q[0] == 0, "R6 first grant", 32'(log_q[0]), 0);
      chk(log_q[1] == 1, "R6 second grant", 32'(log_q[1]), 1);
      chk(log_q[2] == 2, "R6 third grant", 32'(log_q[2]), 2);
    end

    // R6/R7: ports 0 and 2 each keep strobe high for two transfers -> 0,2,0,2
    log_q.delete();
    credits[0] = 2; credits[2] = 2;
    wait_idle();
    chk(log_q.size() == 4, "R7 transfer count", 32'(log_q.size()), 4);
    if (log_q.size() == 4) begin
      chk(log_q[0] == 0 && log_q[1] == 2, "R6 alternation a", 32'(log_q[1]), 2);
      chk(log_q[2] == 0 && log_q[3] == 2, "R6 alternation b", 32'(log_q[3]), 2);
    end

    // R7: lone port with continuous strobe -> exactly 3 transfers, no duplicate
    log_q.delete();
    credits[1] = 3;
    wait_idle();
    chk(log_q.size() == 3, "R7 no duplicate on held strobe", 32'(log_q.size()), 3);

    // R8: byte-enabled writes then full-word read through port 2 and port 0
    fix_en = 1;
    one_xfer(2, 1'b1, 4'b1111, 30'd5, 32'hAABBCCDD);
    one_xfer(0, 1'b1, 4'b1000, 30'd5, 32'h11223344);
    one_xfer(1, 1'b1, 4'b0001, 30'd5, 32'h99887766);
    one_xfer(0, 1'b0, 4'b0000, 30'd5, 32'h0);
    chk(last_rd[0] == 32'h11BBCC66, "R8 byte lanes on readback", last_rd[0], 32'h11BBCC66);
    one_xfer(2, 1'b0, 4'b0001, 30'd5, 32'h0);
    chk(last_rd[2] == 32'h11BBCC66, "R8 read ignores byte enables", last_rd[2], 32'h11BBCC66);
    fix_en = 0;

    // R9: random contention with variable latency, model compared every clock
    eager = 0;
    repeat (3000) begin
      @(negedge clk); #1;
      for (int p = 0; p < NP; p++)
        if (credits[p] == 0 && $urandom_range(5) == 0) credits[p] = 1 + $urandom_range(2);
    end
    wait_idle();
    chk(mr_strobe == 1'b0, "R9 drained", 32'(mr_strobe), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 act=hung exp=done");
      finish_run();
    end
  end
endmodule